// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the address of an instruction fetch into a physical address, or into a fault, in one registered step. A fetch arrives with its program counter, a flag that says the address is already physical, the current privilege mode and the current address-space number. In the cycle the request is presented, the block decides which of five paths applies. These paths are privileged-code bypass, physical mode, malformed virtual address, kernel superpage and translated page. Only a translated page drives a lookup into an external translation buffer. That buffer answers in the same cycle with a hit flag, a physical page number and a per-mode read-enable mask.

One cycle after the request, the block presents the physical address, an uncacheable flag and a four-bit fault vector. At most one bit of the vector is set. Bit 0 is an access violation, bit 1 a translation miss, bit 2 a machine check and bit 3 an unimplemented access. The fetch unit uses the result to start the cache access or to raise the matching exception. Refill of the translation buffer and exception dispatch happen elsewhere.

Top module: `ift_fetch_xlate`

## Requirements
- R1: While rst_n is low at a clock edge, rsp_valid, rsp_pa, rsp_uncached and rsp_fault all become zero, whatever the request inputs carry.
- R2: A request with req_valid high at a clock edge produces rsp_valid high after that edge. With req_valid low, rsp_valid is low after the edge and rsp_pa, rsp_fault and rsp_uncached keep their values.
- R3: When req_pc bit 0 is set, the response is rsp_pa = {req_pc[43:2], 2'b00}, with rsp_fault = 0 and rsp_uncached = 0, and no lookup is issued. This holds regardless of req_phys and mode.
- R4: When req_pc bit 0 is clear and req_phys is set, rsp_pa = req_pc[43:0] and no lookup is issued. If any of req_pc[63:44] is set, rsp_fault = 4'b0100 (machine check) and rsp_uncached = 0.
- R5: On the virtual path, if req_pc[63:47] are not all equal, the result is rsp_fault = 4'b0001 (access violation) and rsp_pa = 0, with no lookup.
- R6: On the virtual path, req_pc[47:41] == 7'h7E selects the superpage, with no lookup. If cur_mode is not 0 (0 = kernel), the result is an access violation with rsp_pa = 0. In kernel mode, rsp_pa = {4'hF, req_pc[39:0]} when req_pc[40] is set, otherwise {4'h0, req_pc[39:0]}.
- R7: Any other virtual fetch drives lk_valid high in the request cycle, with lk_vpn = req_pc[47:13] and lk_asn = cur_asn. If lk_hit is low, the result is rsp_fault = 4'b0010 (miss) and rsp_pa = 0.
- R8: On a lookup hit with permission, rsp_pa = {lk_ppn, req_pc[12:2], 2'b00}.
- R9: On a lookup hit where lk_rd_en[cur_mode] is 0, the result is an access violation with rsp_pa = 0.
- R10: On every path except R3, if no earlier fault applies and bit 43 of the formed physical address is set, rsp_uncached = 1 and rsp_fault = 4'b1000 (unimplemented). rsp_pa keeps the formed address.
- R11: rsp_fault never has more than one bit set. Machine check takes precedence over the uncacheable check.

Fault vector encoding: bit 0 access violation, bit 1 miss, bit 2 machine check, bit 3 unimplemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request present this cycle |
| req_pc | input | 64 | Fetch address; bit 0 marks privileged code |
| req_phys | input | 1 | Address is already physical |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| cur_asn | input | 8 | Current address-space number |
| lk_valid | output | 1 | Lookup request to the translation buffer |
| lk_vpn | output | 35 | Virtual page number looked up |
| lk_asn | output | 8 | Address-space number looked up |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_ppn | input | 31 | Physical page number of the entry |
| lk_rd_en | input | 4 | Read-enable mask of the entry, one bit per mode |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Address lies in uncacheable space |
| rsp_fault | output | 4 | One-hot fault vector |

## Verification
The hardest cases to reach from the ports are those where two rules compete on the same address. One example is a program counter with bit 0 set whose upper bits would otherwise be malformed or out of range. Another is a superpage address that becomes uncacheable through sign extension of bit 40. A third is a lookup hit whose page number sets the uncacheable bit while the permission mask denies the current mode. The bench reaches all of these by crossing eight hand-picked address classes with the privileged-code bit, the physical flag, all four modes, hit and miss, all sixteen permission masks and two page numbers. It computes each expected result from the rules above.

// File: rtl/ift_pkg.sv
// Package: shared types for the instruction fetch address translator.
// Assumes: one fault bit per cause, at most one set per response.
package ift_pkg;

    // Which translation rule applies to a request
    typedef enum logic [2:0] {
        PATH_PAL   = 3'd0,
        PATH_PHYS  = 3'd1,
        PATH_BADVA = 3'd2,
        PATH_SUPER = 3'd3,
        PATH_XLATE = 3'd4
    } ift_path_e;

    localparam int FAULT_W   = 4;
    localparam int FLT_ACV   = 0;
    localparam int FLT_MISS  = 1;
    localparam int FLT_MCHK  = 2;
    localparam int FLT_UNIMP = 3;

endpackage

// File: rtl/ift_path_decode.sv
// Module: ift_path_decode
// Classifies a fetch address into one translation path.
// Assumes: the privileged-code marker (bit 0) outranks the physical flag,
// which outranks virtual address checks.
module ift_path_decode
    import ift_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48,
    parameter int SP_LO   = 41,
    parameter int SP_TAG  = 'h7E
) (
    input  logic [VA_W-1:0] pc,
    input  logic            phys,
    output ift_path_e       path
);
    localparam int SIGN_W   = VA_W - VA_IMPL + 1;
    localparam int SP_TAG_W = VA_IMPL - SP_LO;

    logic [SIGN_W-1:0]   sign_bits;
    logic [SP_TAG_W-1:0] sp_field;
    logic                va_ok;
    logic                is_super;

    assign sign_bits = pc[VA_W-1:VA_IMPL-1];
    assign sp_field  = pc[VA_IMPL-1:SP_LO];

    // Virtual address is well formed when its upper bits are a sign extension
    always_comb begin
        va_ok    = (&sign_bits) || !(|sign_bits);
        is_super = (sp_field == SP_TAG_W'(SP_TAG));
    end

    // Pick the path in priority order
    always_comb begin
        if (pc[0])
            path = PATH_PAL;
        else if (phys)
            path = PATH_PHYS;
        else if (!va_ok)
            path = PATH_BADVA;
        else if (is_super)
            path = PATH_SUPER;
        else
            path = PATH_XLATE;
    end

endmodule

// File: rtl/ift_addr_form.sv
// Module: ift_addr_form
// Forms the raw (full-width) physical address for the chosen path and
// flags the access-violation and miss faults that precede address checks.
// Assumes: lookup response is valid in the same cycle as the request.
module ift_addr_form
    import ift_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 44,
    parameter int PAGE_BITS = 13,
    parameter int SP_LO     = 41,
    parameter int MODE_W    = 2
) (
    input  ift_path_e               path,
    input  logic [VA_W-1:0]         pc,
    input  logic [MODE_W-1:0]       mode,
    input  logic                    lk_hit,
    input  logic [PA_W-PAGE_BITS-1:0] lk_ppn,
    input  logic [(1<<MODE_W)-1:0]  lk_rd_en,
    output logic [VA_W-1:0]         pa_raw,
    output logic                    pre_acv,
    output logic                    pre_miss
);
    localparam int HI_ZERO = VA_W - PA_W;
    localparam int SP_SIGN = SP_LO - 1;
    localparam int SP_EXT  = PA_W - SP_SIGN;

    logic [VA_W-1:0] pal_pa;
    logic [VA_W-1:0] sup_pa;
    logic [VA_W-1:0] xl_pa;
    logic            mode_kernel;
    logic            perm_ok;

    // Address candidates for each path
    always_comb begin
        pal_pa = {{HI_ZERO{1'b0}}, pc[PA_W-1:2], 2'b00};
        if (pc[SP_SIGN])
            sup_pa = {{HI_ZERO{1'b0}}, {SP_EXT{1'b1}}, pc[SP_SIGN-1:0]};
        else
            sup_pa = {{HI_ZERO{1'b0}}, {SP_EXT{1'b0}}, pc[SP_SIGN-1:0]};
        xl_pa = {{HI_ZERO{1'b0}}, lk_ppn, pc[PAGE_BITS-1:2], 2'b00};
    end

    // Mode qualifiers
    always_comb begin
        mode_kernel = (mode == '0);
        perm_ok     = lk_rd_en[mode];
    end

    // Select address and early faults
    always_comb begin
        pa_raw   = '0;
        pre_acv  = 1'b0;
        pre_miss = 1'b0;
        unique case (path)
            PATH_PAL:   pa_raw = pal_pa;
            PATH_PHYS:  pa_raw = pc;
            PATH_BADVA: pre_acv = 1'b1;
            PATH_SUPER: begin
                if (mode_kernel) pa_raw  = sup_pa;
                else             pre_acv = 1'b1;
            end
            PATH_XLATE: begin
                if (!lk_hit)       pre_miss = 1'b1;
                else if (!perm_ok) pre_acv  = 1'b1;
                else               pa_raw   = xl_pa;
            end
            default: pre_acv = 1'b1;
        endcase
    end

endmodule

// File: rtl/ift_fault_resolve.sv
// Module: ift_fault_resolve
// Applies the physical range and cacheability checks and produces the
// one-hot fault vector and final address.
// Assumes: pre_acv/pre_miss are mutually exclusive; privileged-code
// fetches skip all checks.
module ift_fault_resolve
    import ift_pkg::*;
#(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input  ift_path_e           path,
    input  logic [VA_W-1:0]     pa_raw,
    input  logic                pre_acv,
    input  logic                pre_miss,
    output logic [PA_W-1:0]     pa,
    output logic                uncached,
    output logic [FAULT_W-1:0]  fault
);
    logic checked;
    logic out_of_range;
    logic unc_bit;

    // Checks apply to every path except privileged code
    always_comb begin
        checked      = (path != PATH_PAL) && !pre_acv && !pre_miss;
        out_of_range = checked && (|pa_raw[VA_W-1:PA_W]);
        unc_bit      = checked && !out_of_range && pa_raw[PA_W-1];
    end

    // Build the fault vector, one cause at most
    always_comb begin
        fault            = '0;
        fault[FLT_ACV]   = pre_acv;
        fault[FLT_MISS]  = pre_miss;
        fault[FLT_MCHK]  = out_of_range;
        fault[FLT_UNIMP] = unc_bit;
        uncached         = unc_bit;
        pa               = pa_raw[PA_W-1:0];
    end

endmodule

// File: rtl/ift_fetch_xlate.sv
// Module: ift_fetch_xlate (top)
// Translates an instruction fetch address into a physical address or a
// fault, registering the result one cycle after the request.
// Assumes: the external translation buffer answers lk_* combinationally.
module ift_fetch_xlate
    import ift_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL   = 48,
    parameter int PA_W      = 44,
    parameter int PAGE_BITS = 13,
    parameter int SP_LO     = 41,
    parameter int SP_TAG    = 'h7E,
    parameter int MODE_W    = 2,
    parameter int ASN_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_pc,
    input  logic                       req_phys,
    input  logic [MODE_W-1:0]          cur_mode,
    input  logic [ASN_W-1:0]           cur_asn,
    output logic                       lk_valid,
    output logic [VA_IMPL-PAGE_BITS-1:0] lk_vpn,
    output logic [ASN_W-1:0]           lk_asn,
    input  logic                       lk_hit,
    input  logic [PA_W-PAGE_BITS-1:0]  lk_ppn,
    input  logic [(1<<MODE_W)-1:0]     lk_rd_en,
    output logic                       rsp_valid,
    output logic [PA_W-1:0]            rsp_pa,
    output logic                       rsp_uncached,
    output logic [FAULT_W-1:0]         rsp_fault
);
    ift_path_e          path;
    logic [VA_W-1:0]    pa_raw;
    logic               pre_acv;
    logic               pre_miss;
    logic [PA_W-1:0]    pa_nxt;
    logic               unc_nxt;
    logic [FAULT_W-1:0] fault_nxt;

    ift_path_decode #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
    ) decode_i (
        .pc(req_pc), .phys(req_phys), .path(path)
    );

    ift_addr_form #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
        .SP_LO(SP_LO), .MODE_W(MODE_W)
    ) form_i (
        .path(path), .pc(req_pc), .mode(cur_mode),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .pa_raw(pa_raw), .pre_acv(pre_acv), .pre_miss(pre_miss)
    );

    ift_fault_resolve #(
        .VA_W(VA_W), .PA_W(PA_W)
    ) resolve_i (
        .path(path), .pa_raw(pa_raw), .pre_acv(pre_acv), .pre_miss(pre_miss),
        .pa(pa_nxt), .uncached(unc_nxt), .fault(fault_nxt)
    );

    // Drive the lookup port only for translated fetches
    always_comb begin
        lk_valid = req_valid && (path == PATH_XLATE);
        lk_vpn   = req_pc[VA_IMPL-1:PAGE_BITS];
        lk_asn   = cur_asn;
    end

    // Register the response; hold it while no request is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= pa_nxt;
                rsp_uncached <= unc_nxt;
                rsp_fault    <= fault_nxt;
            end
        end
    end

endmodule

// File: rtl/ift_fetch_xlate_chk.sv
// Module: ift_fetch_xlate_chk
// Protocol and result checks for ift_fetch_xlate, attached by bind.
// Assumes: fault bit 3 is unimplemented, bits 0/1 are violation/miss.
module ift_fetch_xlate_chk #(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int FAULT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [VA_W-1:0]    req_pc,
    input logic               req_phys,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic               rsp_valid,
    input logic [PA_W-1:0]    rsp_pa,
    input logic               rsp_uncached,
    input logic [FAULT_W-1:0] rsp_fault
);
    AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_fault)); // R11
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_uncached)); // R2
    AST_LOOKUP_ONLY_VIRTUAL: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> req_valid && !req_pc[0] && !req_phys); // R7
    AST_PAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_pc[0] |=> rsp_fault == '0 && !rsp_uncached && rsp_pa[1:0] == 2'b00); // R3
    AST_MISS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_hit |=> rsp_fault[1]); // R7
    AST_UNC_IS_UNIMP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> rsp_fault == 4'b1000); // R10
    AST_EARLY_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault[0] || rsp_fault[1]) |-> rsp_pa == '0); // R5
endmodule

bind ift_fetch_xlate ift_fetch_xlate_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .FAULT_W(ift_pkg::FAULT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
    .req_phys(req_phys), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault)
);

// File: tb/ift_fetch_xlate_tb_top.sv
`timescale 1ns/1ps
module ift_fetch_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_pc = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [7:0]  cur_asn = '0;
    logic        lk_valid;
    logic [34:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic        lk_hit;
    logic [30:0] lk_ppn;
    logic [3:0]  lk_rd_en;
    logic        rsp_valid;
    logic [43:0] rsp_pa;
    logic        rsp_uncached;
    logic [3:0]  rsp_fault;

    logic        tb_hit = 1'b0;
    logic [30:0] tb_ppn = '0;
    logic [3:0]  tb_mask = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Translation buffer model: answers combinationally from bench settings
    assign lk_hit   = tb_hit;
    assign lk_ppn   = tb_ppn;
    assign lk_rd_en = tb_mask;

    ift_fetch_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_phys(req_phys), .cur_mode(cur_mode), .cur_asn(cur_asn),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .rsp_fault(rsp_fault)
    );

    logic [43:0] e_pa;
    logic        e_unc;
    logic [3:0]  e_flt;
    logic        e_lk;
    string       e_tag;

    // Expected result, from the requirement rules
    task automatic predict(input logic [63:0] pc, input logic phys, input logic [1:0] mode);
        logic [63:0] raw;
        e_pa = '0; e_unc = 1'b0; e_flt = 4'h0; e_lk = 1'b0; raw = '0;
        if (pc[0]) begin
            e_pa = {pc[43:2], 2'b00}; e_tag = "R3";
        end else if (phys) begin
            raw = pc; e_pa = pc[43:0]; e_tag = "R4";
            if (pc[63:44] != 0) e_flt = 4'b0100;
            else if (pc[43]) begin e_flt = 4'b1000; e_unc = 1'b1; e_tag = "R10"; end
        end else if (!(pc[63:47] == '0 || pc[63:47] == '1)) begin
            e_flt = 4'b0001; e_tag = "R5";
        end else if (pc[47:41] == 7'h7E) begin
            e_tag = "R6";
            if (mode != 2'd0) e_flt = 4'b0001;
            else begin
                e_pa = {(pc[40] ? 4'hF : 4'h0), pc[39:0]};
                if (e_pa[43]) begin e_flt = 4'b1000; e_unc = 1'b1; e_tag = "R10"; end
            end
        end else begin
            e_lk = 1'b1;
            if (!tb_hit) begin e_flt = 4'b0010; e_tag = "R7"; end
            else if (!tb_mask[mode]) begin e_flt = 4'b0001; e_tag = "R9"; end
            else begin
                e_pa = {tb_ppn, pc[12:2], 2'b00}; e_tag = "R8";
                if (e_pa[43]) begin e_flt = 4'b1000; e_unc = 1'b1; e_tag = "R10"; end
            end
        end
    endtask

    task automatic run_req(input logic [63:0] pc, input logic phys, input logic [1:0] mode,
                           input logic [7:0] asn);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_phys = phys; cur_mode = mode; cur_asn = asn;
        #1;
        predict(pc, phys, mode);
        checks++;
        if (lk_valid !== e_lk || (e_lk && (lk_vpn !== pc[47:13] || lk_asn !== asn))) begin
            errors++;
            $display("FAIL R7 lookup pc=%h: lk_valid=%b vpn=%h asn=%h expected %b %h %h",
                     pc, lk_valid, lk_vpn, lk_asn, e_lk, pc[47:13], asn);
        end
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_pa !== e_pa || rsp_fault !== e_flt || rsp_uncached !== e_unc) begin
            errors++;
            $display("FAIL %s pc=%h phys=%b mode=%0d: v=%b pa=%h f=%b u=%b expected v=1 pa=%h f=%b u=%b",
                     e_tag, pc, phys, mode, rsp_valid, rsp_pa, rsp_fault, rsp_uncached,
                     e_pa, e_flt, e_unc);
        end
    endtask

    logic [63:0] classes [8];

    initial begin
        logic [43:0] held_pa;
        logic [3:0]  held_f;
        classes[0] = 64'h0000_0000_1234_5678;
        classes[1] = 64'hFFFF_FFF0_0000_A000;
        classes[2] = 64'h0001_0000_0000_0000;
        classes[3] = 64'hFFFF_FC00_0001_2340;
        classes[4] = 64'hFFFF_FD12_3456_7890;
        classes[5] = 64'h0000_0800_0000_1000;
        classes[6] = 64'h8000_0000_0000_4000;
        classes[7] = 64'h0000_7FFF_FFFF_E004;

        // R1: reset holds outputs at zero even with a request present
        req_valid = 1'b1; req_pc = 64'h0000_0000_0000_1235;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_pa !== '0 || rsp_fault !== '0 || rsp_uncached !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: v=%b pa=%h f=%b u=%b expected all zero",
                     rsp_valid, rsp_pa, rsp_fault, rsp_uncached);
        end
        req_valid = 1'b0;
        rst_n = 1'b1;

        // Main sweep over address classes and all qualifiers (R3..R11)
        for (int c = 0; c < 8; c++)
            for (int pal = 0; pal < 2; pal++)
                for (int ph = 0; ph < 2; ph++)
                    for (int m = 0; m < 4; m++)
                        for (int h = 0; h < 2; h++)
                            for (int k = 0; k < 16; k++)
                                for (int p = 0; p < 2; p++) begin
                                    tb_hit  = h[0];
                                    tb_mask = k[3:0];
                                    tb_ppn  = p[0] ? 31'h4000_0001 : 31'h0123_4567;
                                    run_req(classes[c] | 64'(pal), ph[0], m[1:0],
                                            8'(c * 37 + m));
                                end

        // R2: response holds while idle and rsp_valid drops
        tb_hit = 1'b1; tb_mask = 4'hF; tb_ppn = 31'h0000_0ABC;
        run_req(64'h0000_0000_0004_6008, 1'b0, 2'd2, 8'h5A);
        held_pa = rsp_pa; held_f = rsp_fault;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_pa !== held_pa || rsp_fault !== held_f) begin
            errors++;
            $display("FAIL R2 hold: v=%b pa=%h f=%b expected v=0 pa=%h f=%b",
                     rsp_valid, rsp_pa, rsp_fault, held_pa, held_f);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule